// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block sits at the front of a double-precision multiply-add unit that computes z + x·y, or z − x·y when the product is negated. It receives each operand's sign and raw 64-bit pattern, together with a class code that an upstream classifier has already produced. In the same cycle, with no registers, it decides whether the result is fixed by the special-value rules or whether the arithmetic datapath has to run.

When a special value decides the result, the block raises a bypass flag and drives the final 64-bit result. It also raises an invalid-operation flag where one applies. In every other case it raises a proceed flag, and the datapath then does the multiply, alignment, addition and rounding. The block also outputs the effective product sign for the datapath.

The precedence is fixed and asymmetric:
1. A signaling NaN in the addend wins over everything.
2. Next come the NaNs in the multiplier operands, with y's signaling NaN ahead of x's quiet NaN.
3. Last come the product's own special cases, each with its own view of a quiet-NaN or infinite addend.

Top module: `fma_special_resolver`

## Requirements
- R1: While `req_valid` is low, `byp_valid`, `proceed`, `invalid`, `prod_sign` and `byp_result` are all zero.
- R2: While `req_valid` is high, exactly one of `byp_valid` and `proceed` is high, and `invalid` is high only together with `byp_valid`.
- R3: Class codes are 0 zero, 1 normal, 2 subnormal, 3 infinity, 4 quiet NaN and 5 signaling NaN. When the addend's class is 5, the block returns the addend with fraction bit 51 set and raises `invalid`, whatever x and y are.
- R4: Otherwise, if y is a signaling NaN and x is not, the result is y with bit 51 set. If x is a signaling NaN, the result is x with bit 51 set. In both cases `invalid` is raised.
- R5: Otherwise, if y is a quiet NaN and x is not a NaN, y is returned unchanged. If x is a quiet NaN, x is returned unchanged. `invalid` stays low in both cases.
- R6: Otherwise, infinity times zero, in either order, returns the addend unchanged when the addend is a quiet NaN. In any other case it raises `invalid` and returns 0x7FF8000000000000.
- R7: Otherwise, a product with an infinite factor and no zero factor returns the addend when the addend is a quiet NaN. In any other case it returns infinity (exponent all ones, fraction zero) with sign xs XOR ys, even when the addend is an infinity of either sign.
- R8: Otherwise, a product with a zero factor returns infinity with sign zs when the addend is infinite. In any other case it returns the addend unchanged.
- R9: For a product of two finite nonzero factors, a quiet-NaN addend is returned unchanged and an infinite addend gives infinity with sign zs. In any other case `proceed` is raised.
- R10: While `req_valid` is high, `prod_sign` equals xs XOR ys XOR `negate_prod`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Request present this cycle |
| negate_prod | input | 1 | Multiply-subtract variant: negate the product |
| z_cls | input | 3 | Class code of the addend |
| x_cls | input | 3 | Class code of the first factor |
| y_cls | input | 3 | Class code of the second factor |
| zs | input | 1 | Addend sign |
| xs | input | 1 | First factor sign |
| ys | input | 1 | Second factor sign |
| z_op | input | 64 | Raw addend |
| x_op | input | 64 | Raw first factor |
| y_op | input | 64 | Raw second factor |
| byp_valid | output | 1 | Result is a special value on `byp_result` |
| byp_result | output | 64 | Special-value result |
| invalid | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Arithmetic datapath must compute the result |
| prod_sign | output | 1 | Effective product sign |

## Verification
The embedded assertions check on every evaluation that bypass and proceed are mutually exclusive and cover every request. They also check that an invalid flag never appears without a bypass, that an idle request drives nothing, that a signaling-NaN addend always yields a quieted addend with invalid raised, and that the product sign follows its inputs.

Only the bench's scenarios can show the full precedence order, because those checks need the expected value for a given mix of operand classes. That covers:
- NaN selection between x and y;
- whether an infinite addend is overridden by an infinite product;
- infinity times zero against a quiet-NaN addend;
- an exact addend pass-through when a factor is zero.

// File: rtl/fma_special_resolver.sv
module fma_special_resolver #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int DW     = EXP_W + FRAC_W + 1
) (
  input  logic          req_valid,
  input  logic          negate_prod,
  input  logic [2:0]    z_cls,
  input  logic [2:0]    x_cls,
  input  logic [2:0]    y_cls,
  input  logic          zs,
  input  logic          xs,
  input  logic          ys,
  input  logic [DW-1:0] z_op,
  input  logic [DW-1:0] x_op,
  input  logic [DW-1:0] y_op,
  output logic          byp_valid,
  output logic [DW-1:0] byp_result,
  output logic          invalid,
  output logic          proceed,
  output logic          prod_sign
);
  localparam logic [2:0] C_ZERO = 3'd0;
  localparam logic [2:0] C_INF  = 3'd3;
  localparam logic [2:0] C_QNAN = 3'd4;
  localparam logic [2:0] C_SNAN = 3'd5;
  localparam int QBIT = FRAC_W - 1;
  localparam logic [DW-1:0] QUIET_MASK = DW'(1) << QBIT;
  localparam logic [DW-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [DW-1:0] make_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  logic z_snan, z_qnan, z_inf;
  logic x_snan, x_qnan, x_nan, x_inf, x_zero;
  logic y_snan, y_qnan, y_inf, y_zero;

  assign z_snan = (z_cls == C_SNAN);
  assign z_qnan = (z_cls == C_QNAN);
  assign z_inf  = (z_cls == C_INF);
  assign x_snan = (x_cls == C_SNAN);
  assign x_qnan = (x_cls == C_QNAN);
  assign x_nan  = x_snan | x_qnan;
  assign x_inf  = (x_cls == C_INF);
  assign x_zero = (x_cls == C_ZERO);
  assign y_snan = (y_cls == C_SNAN);
  assign y_qnan = (y_cls == C_QNAN);
  assign y_inf  = (y_cls == C_INF);
  assign y_zero = (y_cls == C_ZERO);

  assign prod_sign = req_valid & (xs ^ ys ^ negate_prod);

  always_comb begin
    byp_valid  = 1'b0;
    byp_result = '0;
    invalid    = 1'b0;
    proceed    = 1'b0;
    if (req_valid) begin
      byp_valid = 1'b1;
      if (z_snan) begin
        byp_result = z_op | QUIET_MASK;
        invalid    = 1'b1;
      end else if (y_snan && !x_snan) begin
        byp_result = y_op | QUIET_MASK;
        invalid    = 1'b1;
      end else if (x_snan) begin
        byp_result = x_op | QUIET_MASK;
        invalid    = 1'b1;
      end else if (y_qnan && !x_nan) begin
        byp_result = y_op;
      end else if (x_qnan) begin
        byp_result = x_op;
      end else if ((x_inf && y_zero) || (x_zero && y_inf)) begin
        if (z_qnan) byp_result = z_op;
        else begin
          byp_result = DEF_NAN;
          invalid    = 1'b1;
        end
      end else if (x_inf || y_inf) begin
        byp_result = z_qnan ? z_op : make_inf(xs ^ ys);
      end else if (x_zero || y_zero) begin
        byp_result = z_inf ? make_inf(zs) : z_op;
      end else if (z_qnan) begin
        byp_result = z_op;
      end else if (z_inf) begin
        byp_result = make_inf(zs);
      end else begin
        byp_valid = 1'b0;
        proceed   = 1'b1;
      end
    end
  end

  always_comb begin
    if (req_valid === 1'b1) begin
      // R2
      one_path_chk: assert (byp_valid ^ proceed);
      // R2
      inv_needs_byp_chk: assert (!invalid || byp_valid);
      // R10
      prod_sign_chk: assert (prod_sign == (xs ^ ys ^ negate_prod));
      if (z_cls == C_SNAN) begin
        // R3
        z_snan_chk: assert (invalid && byp_valid && byp_result[QBIT]);
      end
    end else if (req_valid === 1'b0) begin
      // R1
      idle_quiet_chk: assert (!byp_valid && !proceed && !invalid && !prod_sign && byp_result == '0);
    end
  end
endmodule

// File: tb/fma_special_resolver_bench.sv
`timescale 1ns/1ps
module fma_special_resolver_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid, negate_prod, zs, xs, ys;
  logic [2:0]  z_cls, x_cls, y_cls;
  logic [63:0] z_op, x_op, y_op, byp_result;
  logic        byp_valid, invalid, proceed, prod_sign;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fma_special_resolver u_fma_special_resolver (
    .req_valid(req_valid), .negate_prod(negate_prod),
    .z_cls(z_cls), .x_cls(x_cls), .y_cls(y_cls),
    .zs(zs), .xs(xs), .ys(ys),
    .z_op(z_op), .x_op(x_op), .y_op(y_op),
    .byp_valid(byp_valid), .byp_result(byp_result),
    .invalid(invalid), .proceed(proceed), .prod_sign(prod_sign)
  );

  function automatic logic [63:0] build(input int cls, input logic s);
    logic [51:0] f;
    logic [10:0] e;
    f = {$urandom, $urandom};
    e = 11'($urandom_range(1, 2046));
    case (cls)
      0: return {s, 63'd0};
      1: return {s, e, f};
      2: return {s, 11'd0, (f == 0) ? 52'd1 : f};
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, (f[50:0] == 0) ? 51'd5 : f[50:0]};
    endcase
  endfunction

  function automatic logic [63:0] inf_of(input logic s);
    return {s, 11'h7FF, 52'd0};
  endfunction

  // Reference: expected {bypass, invalid, proceed}, result and requirement tag
  task automatic model(output logic eb, output logic ei, output logic ep,
                       output logic [63:0] er, output string tag);
    bit xnan, ynan, xz, yz, xi, yi;
    eb = 1; ei = 0; ep = 0; er = 0; tag = "R1";
    if (!req_valid) begin eb = 0; return; end
    xnan = (x_cls == 4) || (x_cls == 5);
    ynan = (y_cls == 4) || (y_cls == 5);
    xz = (x_cls == 0); yz = (y_cls == 0);
    xi = (x_cls == 3); yi = (y_cls == 3);
    if (z_cls == 5) begin er = z_op; er[51] = 1; ei = 1; tag = "R3"; end
    else if (xnan || ynan) begin
      if (x_cls == 5) begin er = x_op; er[51] = 1; ei = 1; tag = "R4"; end
      else if (y_cls == 5) begin er = y_op; er[51] = 1; ei = 1; tag = "R4"; end
      else if (x_cls == 4) begin er = x_op; tag = "R5"; end
      else begin er = y_op; tag = "R5"; end
    end else if ((xi || yi) && (xz || yz)) begin
      tag = "R6";
      if (z_cls == 4) er = z_op;
      else begin er = 64'h7FF8_0000_0000_0000; ei = 1; end
    end else if (xi || yi) begin
      tag = "R7";
      er = (z_cls == 4) ? z_op : inf_of(xs ^ ys);
    end else if (xz || yz) begin
      tag = "R8";
      er = (z_cls == 3) ? inf_of(zs) : z_op;
    end else begin
      tag = "R9";
      if (z_cls == 4) er = z_op;
      else if (z_cls == 3) er = inf_of(zs);
      else begin eb = 0; ep = 1; end
    end
  endtask

  task automatic check_now();
    logic eb, ei, ep, es;
    logic [63:0] er;
    string tag;
    model(eb, ei, ep, er, tag);
    checks++;
    if (byp_valid !== eb || invalid !== ei || proceed !== ep || byp_result !== er) begin
      errors++;
      $display("FAIL %s: got byp=%b inv=%b proc=%b res=%h, expected byp=%b inv=%b proc=%b res=%h",
               tag, byp_valid, invalid, proceed, byp_result, eb, ei, ep, er);
    end
    es = req_valid & (xs ^ ys ^ negate_prod);
    checks++;
    if (prod_sign !== es) begin
      errors++;
      $display("FAIL R10: prod_sign got %b expected %b", prod_sign, es);
    end
  endtask

  task automatic apply(input bit v, input bit neg, input int zc, input int xc, input int yc,
                       input bit s_z, input bit s_x, input bit s_y);
    @(negedge clk);
    req_valid = v; negate_prod = neg;
    z_cls = 3'(zc); x_cls = 3'(xc); y_cls = 3'(yc);
    zs = s_z; xs = s_x; ys = s_y;
    z_op = build(zc, s_z); x_op = build(xc, s_x); y_op = build(yc, s_y);
    #2;
    check_now();
  endtask

  initial begin
    req_valid = 0; negate_prod = 0; z_cls = 0; x_cls = 0; y_cls = 0;
    zs = 0; xs = 0; ys = 0; z_op = 0; x_op = 0; y_op = 0;
    // R1: idle with busy-looking operands
    apply(0, 1, 5, 3, 0, 1, 1, 0);
    // R3: addend sNaN beats x/y sNaN
    apply(1, 0, 5, 5, 5, 0, 1, 1);
    // R4: both sNaN -> x; y sNaN with x qNaN -> y
    apply(1, 0, 1, 5, 5, 0, 0, 0);
    apply(1, 0, 4, 4, 5, 0, 0, 1);
    // R5: x qNaN over y qNaN; y qNaN with x normal
    apply(1, 0, 4, 4, 4, 0, 1, 0);
    apply(1, 1, 3, 1, 4, 0, 0, 0);
    // R6: inf*zero both orders, qNaN addend and not
    apply(1, 0, 3, 3, 0, 1, 0, 1);
    apply(1, 0, 4, 0, 3, 0, 1, 1);
    // R7: inf*normal against opposite-signed inf addend
    apply(1, 1, 3, 3, 1, 0, 1, 0);
    apply(1, 0, 4, 2, 3, 0, 0, 1);
    // R8: zero factor with inf addend and with subnormal addend
    apply(1, 0, 3, 0, 1, 1, 0, 0);
    apply(1, 0, 2, 2, 0, 1, 1, 1);
    // R9: finite products
    apply(1, 0, 4, 1, 2, 0, 0, 0);
    apply(1, 0, 3, 2, 2, 1, 0, 0);
    apply(1, 1, 1, 1, 1, 0, 1, 1);
    apply(1, 0, 0, 1, 2, 1, 0, 1);
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 5),
            $urandom_range(0, 5), $urandom_range(0, 5),
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    done = 1;
  end

  initial begin
    fork
      wait (done == 1);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule